// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. When paging is on, it reads two table entries over a 32-bit memory port: first a directory entry, then a page table entry. The address is split into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. Along the way it sets the accessed flag in every entry it uses and the dirty flag in the second-level entry on a write. It also checks user/supervisor and read/write protection, using the combined rights of both levels.

A successful walk ends with a one-cycle `done` pulse. With it come the physical address, the combined permissions and the two caching attribute bits, ready for a translation-cache fill. The caching bits are passed along and have no effect inside the block. A failed walk ends with a one-cycle `fault` pulse, vector 14, and the linear address held in a fault-address register. When paging is off, the linear address is returned unchanged and no memory access is made.

The controller is one state machine. `ST_IDLE` accepts a request and goes to `ST_DIR_RD`, or to `ST_DONE` when paging is off. `ST_DIR_RD` goes to `ST_FAULT` if the entry is not present, to `ST_DIR_WR` if its accessed flag is clear, and to `ST_TBL_RD` otherwise. `ST_DIR_WR` goes to `ST_TBL_RD`. `ST_TBL_RD` goes to `ST_FAULT` if the entry is not present or the access is not allowed, to `ST_TBL_WR` if a flag must be set, and to `ST_DONE` otherwise. `ST_TBL_WR` goes to `ST_DONE`. Both `ST_DONE` and `ST_FAULT` return to `ST_IDLE` after one cycle.

Top module: `pt_walker`

## Requirements
- R1: With `paging_en`=0 at acceptance, `done` is high in the cycle after the accepting edge and `phys_addr` equals the request's linear address. No memory access is made, permissions read as 1 and `cache_attr` reads 0.
- R2: The first read goes to the directory base (bits 31:12) plus linear bits 31:22 times 4. The second read goes to the directory entry's frame (bits 31:12) plus linear bits 21:12 times 4.
- R3: On success, `phys_addr` is the page table entry's bits 31:12 followed by linear bits 11:0.
- R4: If the present flag (bit 0) of either entry is 0, the walk ends with `fault`, `fault_vec`=14 and `fault_addr` equal to the linear address. No later entry is read or written.
- R5: The accessed flag (bit 5) of each entry used is set through a write of the read value with bit 5 set. That write is made only when bit 5 was clear, and no write ever clears a flag.
- R6: The dirty flag (bit 6) of the page table entry is set only by a write access. A read leaves it unchanged.
- R7: Privilege levels 0 to 2 are supervisor and level 3 is user. A user access faults unless the user/supervisor flag (bit 2) is 1 in both entries.
- R8: A user write faults unless the read/write flag (bit 1) is 1 in both entries. Supervisor writes ignore bit 1. A faulting access writes no flag into the page table entry.
- R9: On success, `perm_user` and `perm_write` are the AND of bits 2 and of bits 1 of both entries. `cache_attr` is {bit 4, bit 3} of the page table entry.
- R10: `fault_addr` changes only when a walk ends in a fault and holds its value across successful walks.
- R11: Once `mem_req` is raised, it stays high with the same `mem_addr` and `mem_we` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_cpl | input | 2 | Current privilege level |
| paging_en | input | 1 | Paging enable |
| dir_base | input | 32 | Directory base register (bits 31:12 used) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful translation pulse |
| phys_addr | output | 32 | Physical address, valid with `done` |
| perm_user | output | 1 | Combined user-access right |
| perm_write | output | 1 | Combined write right |
| cache_attr | output | 2 | Caching attributes {bit 4, bit 3} |
| fault | output | 1 | Page fault pulse |
| fault_vec | output | 8 | Exception vector, 14 with `fault` |
| fault_addr | output | 32 | Faulting linear address register |

## Verification
Setting the accessed and dirty flags fall due in the same page-table write when a write hits an entry that has both flags clear. The bench builds such entries and checks that exactly one write carries both bits. A protection fault and a pending accessed-flag update also fall in the same cycle, in `ST_TBL_RD`. Entries with a clear accessed flag are hit with user accesses that violate their rights, and the bench checks that the fault wins and the table word is left unchanged. The bench judges each walk by counting memory writes and comparing the words in its memory model against values it computes itself.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WR,
        ST_TBL_RD,
        ST_TBL_WR,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    // Flag positions shared by both entry levels
    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_WT = 3;
    localparam int BIT_CD = 4;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
    parameter int AW    = 32,
    parameter int IDX_W = 10,
    parameter int OFS_W = 12
) (
    input  logic [AW-OFS_W-1:0] base_frame,
    input  logic [AW-OFS_W-1:0] dir_frame,
    input  logic [AW-1:0]       lin,
    input  logic                sel_table,
    output logic [AW-1:0]       entry_addr
);
    localparam int DIR_LSB = OFS_W + IDX_W;

    logic [AW-1:0] dir_addr;
    logic [AW-1:0] tbl_addr;

    always_comb begin
        dir_addr   = {base_frame, {OFS_W{1'b0}}} + (AW'(lin[AW-1:DIR_LSB]) << 2);
        tbl_addr   = {dir_frame,  {OFS_W{1'b0}}} + (AW'(lin[DIR_LSB-1:OFS_W]) << 2);
        entry_addr = sel_table ? tbl_addr : dir_addr;
    end
endmodule

// File: rtl/pt_walk_perm.sv
module pt_walk_perm (
    input  logic       dir_us,
    input  logic       dir_rw,
    input  logic       tbl_us,
    input  logic       tbl_rw,
    input  logic [1:0] cpl,
    input  logic       is_write,
    output logic       eff_user,
    output logic       eff_write,
    output logic       violation
);
    logic user_mode;

    always_comb begin
        user_mode = (cpl == 2'd3);
        eff_user  = dir_us & tbl_us;
        eff_write = dir_rw & tbl_rw;
        violation = user_mode & (~eff_user | (is_write & ~eff_write));
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int AW        = 32,
    parameter int IDX_W     = 10,
    parameter int OFS_W     = 12,
    parameter int VEC_W     = 8,
    parameter int FAULT_VEC = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_lin,
    input  logic          req_write,
    input  logic [1:0]    req_cpl,
    input  logic          paging_en,
    input  logic [AW-1:0] dir_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] phys_addr,
    output logic          perm_user,
    output logic          perm_write,
    output logic [1:0]    cache_attr,
    output logic          fault,
    output logic [VEC_W-1:0] fault_vec,
    output logic [AW-1:0] fault_addr
);
    localparam int FRAME_W = AW - OFS_W;

    walk_state_t state_q, state_d;

    logic [AW-1:0]      lin_q, dir_q, tbl_q, fault_addr_q;
    logic [FRAME_W-1:0] base_q;
    logic               wr_q, pg_q;
    logic [1:0]         cpl_q;
    logic [AW-1:0]      tbl_cur, entry_addr;
    logic               eff_user, eff_write, violation, tbl_needs_wr;
    logic [OFS_W-1:0]   unused_base_low;

    assign unused_base_low = dir_base[OFS_W-1:0];

    // In ST_TBL_RD the decision uses the word arriving on the port
    assign tbl_cur = (state_q == ST_TBL_RD) ? mem_rdata : tbl_q;

    pt_walk_addr #(.AW(AW), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_addr (
        .base_frame (base_q),
        .dir_frame  (dir_q[AW-1:OFS_W]),
        .lin        (lin_q),
        .sel_table  ((state_q == ST_TBL_RD) || (state_q == ST_TBL_WR)),
        .entry_addr (entry_addr)
    );

    pt_walk_perm u_perm (
        .dir_us    (dir_q[BIT_US]),
        .dir_rw    (dir_q[BIT_RW]),
        .tbl_us    (tbl_cur[BIT_US]),
        .tbl_rw    (tbl_cur[BIT_RW]),
        .cpl       (cpl_q),
        .is_write  (wr_q),
        .eff_user  (eff_user),
        .eff_write (eff_write),
        .violation (violation)
    );

    assign tbl_needs_wr = ~mem_rdata[BIT_A] | (wr_q & ~mem_rdata[BIT_D]);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = paging_en ? ST_DIR_RD : ST_DONE;
            ST_DIR_RD: if (mem_ack) begin
                           if (!mem_rdata[BIT_P])      state_d = ST_FAULT;
                           else if (!mem_rdata[BIT_A]) state_d = ST_DIR_WR;
                           else                        state_d = ST_TBL_RD;
                       end
            ST_DIR_WR: if (mem_ack) state_d = ST_TBL_RD;
            ST_TBL_RD: if (mem_ack) begin
                           if (!mem_rdata[BIT_P] || violation) state_d = ST_FAULT;
                           else if (tbl_needs_wr)              state_d = ST_TBL_WR;
                           else                                state_d = ST_DONE;
                       end
            ST_TBL_WR: if (mem_ack) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk context and captured entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q        <= '0;
            base_q       <= '0;
            wr_q         <= 1'b0;
            pg_q         <= 1'b0;
            cpl_q        <= '0;
            dir_q        <= '0;
            tbl_q        <= '0;
            fault_addr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                lin_q  <= req_lin;
                base_q <= dir_base[AW-1:OFS_W];
                wr_q   <= req_write;
                pg_q   <= paging_en;
                cpl_q  <= req_cpl;
            end
            if (state_q == ST_DIR_RD && mem_ack) dir_q <= mem_rdata;
            if (state_q == ST_TBL_RD && mem_ack) tbl_q <= mem_rdata;
            if (state_d == ST_FAULT && state_q != ST_FAULT) fault_addr_q <= lin_q;
        end
    end

    // Outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        unique case (state_q)
            ST_DIR_RD, ST_TBL_RD: mem_req = 1'b1;
            ST_DIR_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = dir_q;
                mem_wdata[BIT_A] = 1'b1;
            end
            ST_TBL_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = tbl_q;
                mem_wdata[BIT_A] = 1'b1;
                if (wr_q) mem_wdata[BIT_D] = 1'b1;
            end
            default: ;
        endcase
        mem_addr   = entry_addr;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        fault      = (state_q == ST_FAULT);
        fault_vec  = fault ? VEC_W'(FAULT_VEC) : '0;
        fault_addr = fault_addr_q;
        phys_addr  = pg_q ? {tbl_q[AW-1:OFS_W], lin_q[OFS_W-1:0]} : lin_q;
        perm_user  = pg_q ? eff_user  : 1'b1;
        perm_write = pg_q ? eff_write : 1'b1;
        cache_attr = pg_q ? {tbl_q[BIT_CD], tbl_q[BIT_WT]} : 2'b00;
    end

    // Assertions
    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && req_valid && !paging_en |=> done && phys_addr == $past(req_lin));

    p_fault_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_addr == lin_q);

    p_fault_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> fault);

    p_accessed_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BIT_A]);

    p_dirty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && state_q == ST_TBL_WR && !wr_q |-> mem_wdata[BIT_D] == tbl_q[BIT_D]);

    p_user_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && pg_q && cpl_q == 2'd3 |-> perm_user);

    p_user_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && pg_q && cpl_q == 2'd3 && wr_q |-> perm_write);

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpl = '0;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = 32'h0000_1000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        busy, done, perm_user, perm_write, fault;
    logic [31:0] phys_addr, fault_addr;
    logic [1:0]  cache_attr;
    logic [7:0]  fault_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
        .req_write(req_write), .req_cpl(req_cpl), .paging_en(paging_en),
        .dir_base(dir_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .phys_addr(phys_addr),
        .perm_user(perm_user), .perm_write(perm_write), .cache_attr(cache_attr),
        .fault(fault), .fault_vec(fault_vec), .fault_addr(fault_addr)
    );

    // Memory model: 16 KB, variable ack latency
    logic [31:0] mem [0:4095];
    int          n_wr = 0;
    int          n_acc = 0;
    logic [31:0] acc_log [0:7];
    int          dly = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            dly     <= 0;
        end else if (mem_req && !mem_ack) begin
            if (dly == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[13:2]];
                acc_log[n_acc % 8] <= mem_addr;
                n_acc <= n_acc + 1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    n_wr <= n_wr + 1;
                end
                dly <= int'($urandom % 3);
            end else begin
                dly <= dly - 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] prev_faddr = '0;

    task automatic walk(input logic [31:0] lin, input bit wr, input logic [1:0] cpl, input bit pg);
        logic [31:0] pde_a, pte_a, pde, pte, new_pde, new_pte, e_phys;
        bit e_fault, e_pu, e_pw, user, viol, got;
        logic [1:0] e_cache;
        int e_wr, e_acc, wr0, acc0;
        string tag;
        e_fault = 0; e_wr = 0; e_acc = 0; e_pu = 1; e_pw = 1; e_cache = 0;
        e_phys = lin; tag = "R1";
        pde_a = 32'h1000 + {20'd0, lin[31:22], 2'b00};
        pde = mem[pde_a[13:2]]; new_pde = pde;
        pte_a = 0; pte = 0; new_pte = 0;
        if (pg) begin
            e_acc = 1;
            if (!pde[0]) begin
                e_fault = 1; tag = "R4";
            end else begin
                new_pde = pde | 32'h20;
                if (!pde[5]) begin e_wr++; e_acc++; end
                pte_a = {pde[31:12], 12'h0} + {20'd0, lin[21:12], 2'b00};
                pte = mem[pte_a[13:2]]; new_pte = pte;
                e_acc++;
                user = (cpl == 2'd3);
                e_pu = pde[2] & pte[2];
                e_pw = pde[1] & pte[1];
                viol = user && (!e_pu || (wr && !e_pw));
                if (!pte[0]) begin
                    e_fault = 1; tag = "R4";
                end else if (viol) begin
                    e_fault = 1; tag = e_pu ? "R8" : "R7";
                end else begin
                    tag = "R3";
                    new_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                    if (new_pte != pte) begin e_wr++; e_acc++; end
                    e_phys = {pte[31:12], lin[11:0]};
                    e_cache = {pte[4], pte[3]};
                end
            end
        end
        @(negedge clk);
        wr0 = n_wr; acc0 = n_acc;
        req_valid = 1; req_lin = lin; req_write = wr; req_cpl = cpl; paging_en = pg;
        @(negedge clk);
        req_valid = 0;
        got = 0;
        for (int i = 0; i < 60; i++) begin
            if (done || fault) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, "watchdog", 32'(got), 32'd1);
        if (!got) return;
        chk(fault == e_fault, tag, 32'(fault), 32'(e_fault));
        if (e_fault) begin
            chk(fault_addr == lin, "R4 fault_addr", fault_addr, lin);
            chk(fault_vec == 8'd14, "R4 vector", 32'(fault_vec), 32'd14);
            prev_faddr = lin;
        end else begin
            chk(phys_addr == e_phys, pg ? "R3 phys" : "R1 phys", phys_addr, e_phys);
            chk(perm_user == e_pu && perm_write == e_pw, "R9 perms",
                {30'd0, perm_user, perm_write}, {30'd0, e_pu, e_pw});
            chk(cache_attr == e_cache, "R9 cache", 32'(cache_attr), 32'(e_cache));
            chk(fault_addr == prev_faddr, "R10 hold", fault_addr, prev_faddr);
        end
        chk(n_wr - wr0 == e_wr, "R5 write count", 32'(n_wr - wr0), 32'(e_wr));
        chk(n_acc - acc0 == e_acc, "R11 access count", 32'(n_acc - acc0), 32'(e_acc));
        if (pg) begin
            chk(acc_log[acc0 % 8] == pde_a, "R2 dir addr", acc_log[acc0 % 8], pde_a);
            chk(mem[pde_a[13:2]] == new_pde, "R5 dir word", mem[pde_a[13:2]], new_pde);
            if (pde[0]) begin
                chk(acc_log[(acc0 + e_acc - 1 - ((new_pte != pte && !e_fault) ? 1 : 0)) % 8] == pte_a,
                    "R2 table addr", acc_log[(acc0 + e_acc - 1 - ((new_pte != pte && !e_fault) ? 1 : 0)) % 8], pte_a);
                chk(mem[pte_a[13:2]] == new_pte, "R6 table word", mem[pte_a[13:2]], new_pte);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "reset outputs",
            {28'd0, busy, done, fault, mem_req}, 32'd0);
        chk(fault_addr == 32'd0, "R10 reset fault_addr", fault_addr, 32'd0);
        rst_n = 1;

        // R1 bypass
        walk(32'hDEAD_BEEF, 1, 2'd3, 0);
        // R4 directory not present
        mem[1024 + 1] = 32'h0000_2006;
        walk(32'h0040_0123, 0, 2'd0, 0);
        walk(32'h0040_0123, 0, 2'd0, 1);
        // R4 table not present, directory accessed flag still set (R5)
        mem[1024 + 2] = 32'h0000_2007;
        mem[2048 + 5] = 32'hABCD_E006;
        walk(32'h0080_5FFF, 0, 2'd0, 1);
        // R5/R6 write with A and D both clear: one write carries both
        mem[2048 + 6] = 32'h1234_5017;
        walk(32'h0080_6ABC, 1, 2'd3, 1);
        // Already accessed and dirty: no writes
        walk(32'h0080_6ABC, 1, 2'd3, 1);
        // R6 read with A clear: A only, D untouched
        mem[2048 + 7] = 32'h0BAD_0007;
        walk(32'h0080_7004, 0, 2'd1, 1);
        // R7 user to supervisor page, A clear on table: fault wins, no write
        mem[2048 + 8] = 32'h5555_5003;
        walk(32'h0080_8000, 0, 2'd3, 1);
        // R8 supervisor write to read-only page passes
        mem[2048 + 9] = 32'h7777_7005;
        walk(32'h0080_9010, 1, 2'd0, 1);
        // R8 user write to read-only page faults
        mem[2048 + 10] = 32'h7777_8005;
        walk(32'h0080_A010, 1, 2'd3, 1);

        // Random tables
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] r;
            r = $urandom;
            mem[1024 + i] = {19'd1, r[31], 5'd0, r[6:1], (r[10:8] != 3'd0)};
        end
        for (int i = 2048; i < 4096; i++) begin
            logic [31:0] r;
            r = $urandom;
            mem[i] = {r[31:12], 5'd0, r[6:1], (r[10:8] != 3'd0)};
        end
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            walk($urandom, r[0], r[2:1], (r[5:3] != 3'd0));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule